// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block models the command interpreter of a parallel NOR flash device. Bus writes arrive as single-cycle strobes carrying an address and a data byte. Each command needs a two-write unlock prefix. The decoder recognises the program, sector-erase and chip-erase sequences, an identification mode and a reset command. It then runs the embedded operation as a cycle-counted busy period and reports progress on a ready flag, a toggle bit and the set of sectors still queued for erase.

Several sectors can be erased together. After the first sector command, more sector commands join the erase set if each one arrives before a window that restarts on every accepted sector has expired. Any other write inside that window, including a fresh unlock, abandons the whole set. An erase can be suspended and later resumed, and writes are ignored for a fixed latency after the suspend. A hardware reset input aborts any operation and keeps the device busy for a fixed recovery time. All time windows are given in microseconds and converted to clock cycles through a clock-frequency parameter.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The sequence AAh@555h, 55h@2AAh, A0h@555h followed by any write starts a program. `ready_o` is low from the cycle after that data write for exactly PROG_CYC cycles, then returns high.
- R2: An unlock write with the wrong address or wrong data returns the decoder to read mode. A command byte that follows it is then ignored, and array reads return FFFFh.
- R3: After unlock, 80h@555h and a second unlock, the erase set is loaded from the next write. Data 30h marks the sector given by address bits [ADDR_W-1 -: log2(NUM_SECT)], and 10h@555h marks all sectors. `erase_set_o` shows the set one cycle after the write.
- R4: In the accumulation window, a 30h write adds its sector and restarts the window of CLK_MHZ*ACCUM_US cycles. A 30h write that arrives after the window has expired is ignored.
- R5: Any write in the accumulation window other than data 30h clears the erase set and returns the decoder to read mode with `ready_o` high.
- R6: Erase begins when the window expires. Queued sectors are erased lowest index first, ERASE_CYC cycles each. Each bit clears when its sector finishes, and `ready_o` stays low until the set is empty.
- R7: B0h written during an erase suspends it. All writes are ignored for CLK_MHZ*SUSP_US cycles, after which `ready_o` goes high with the set held. A 30h write then resumes the erase with its progress preserved.
- R8: After unlock and 90h@555h, a read at byte offset 06h returns the lock code: 0001h when `lock_sel_i`=00, 0041h when 01, and 0081h when 1x. Offset A0h returns 0000h. F0h exits to array reads.
- R9: While busy, each read returns a status word whose bit 6 is the toggle bit. The toggle bit inverts on each such read, and `toggle_o` shows its current value.
- R10: Asserting `hwrst_i` clears the erase set and aborts any operation. The decoder then stays busy and ignores writes for CLK_MHZ*RST_US cycles from the assertion before it returns to read mode.
- R11: Writes during a program, including B0h, are ignored, and the program still ends after PROG_CYC cycles.
- R12: F0h written at any step of an incomplete command sequence returns the decoder to read mode. It starts no operation and changes no sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hwrst_i | input | 1 | Device hardware reset, aborts embedded operations |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data byte |
| rd_en_i | input | 1 | Bus read strobe |
| rd_addr_i | input | 8 | Read byte offset |
| lock_sel_i | input | 2 | Lock state of the protected region |
| rd_data_o | output | 16 | Read data, valid the cycle after `rd_en_i` |
| ready_o | output | 1 | High when no embedded operation or recovery is running |
| toggle_o | output | 1 | Status toggle bit |
| erase_set_o | output | NUM_SECT | Sectors queued for erase |

## Verification
The decoder samples a write on the clock edge where the strobe is high. `ready_o` and `erase_set_o` change at that same edge, so the bench checks them at the falling edge that follows. Read data is registered: the bench pushes the expected word into a queue when it issues a read, and the monitor pops and compares it at the falling edge one cycle later. Busy periods end a fixed number of edges after the write that started them: PROG_CYC, window+k*ERASE_CYC, the suspend latency, or the reset recovery. The bench samples `ready_o` at the last busy edge and at the first ready edge. This brackets every window to the exact cycle.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam logic [7:0]  CMD_UNL_A = 8'hAA;
    localparam logic [7:0]  CMD_UNL_B = 8'h55;
    localparam logic [7:0]  CMD_PROG  = 8'hA0;
    localparam logic [7:0]  CMD_ERASE = 8'h80;
    localparam logic [7:0]  CMD_SECT  = 8'h30;
    localparam logic [7:0]  CMD_CHIP  = 8'h10;
    localparam logic [7:0]  CMD_IDENT = 8'h90;
    localparam logic [7:0]  CMD_EXIT  = 8'hF0;
    localparam logic [7:0]  CMD_SUSP  = 8'hB0;
    localparam logic [11:0] ADR_A     = 12'h555;
    localparam logic [11:0] ADR_B     = 12'h2AA;
    localparam logic [7:0]  OFS_LOCK  = 8'h06;

    typedef enum logic [3:0] {
        S_READ, S_UNL1, S_UNL2, S_PGM_DATA, S_ERA_CMD, S_ERA_UNL1, S_ERA_UNL2,
        S_ACCUM, S_ERASING, S_PROGRAMMING, S_SUSP_LAT, S_SUSPENDED, S_IDENT,
        S_RESETTING
    } fcd_state_e;

    typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS, RM_HOLD} rd_mode_e;

    function automatic int unsigned imax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_busy(fcd_state_e s);
        return s inside {S_ACCUM, S_ERASING, S_PROGRAMMING, S_SUSP_LAT, S_RESETTING};
    endfunction

    function automatic rd_mode_e mode_of(fcd_state_e s);
        if (s == S_RESETTING) return RM_HOLD;
        if (is_busy(s))       return RM_STATUS;
        if (s == S_IDENT)     return RM_IDENT;
        return RM_ARRAY;
    endfunction

    function automatic logic [15:0] lock_code(logic [1:0] sel);
        if (sel[1])  return 16'h0081;
        if (sel[0])  return 16'h0041;
        return 16'h0001;
    endfunction

endpackage

// File: rtl/fcd_erase_q.sv
module fcd_erase_q
    import fcd_pkg::*;
#(
    parameter int NUM_SECT = 8,
    localparam int SECT_W  = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear_i,
    input  logic                fill_i,
    input  logic                retire_i,
    input  logic                add_i,
    input  logic [SECT_W-1:0]   add_idx_i,
    output logic [NUM_SECT-1:0] set_o,
    output logic                last_o
);
    logic [NUM_SECT-1:0] set_q;
    logic [NUM_SECT-1:0] lowest;

    assign lowest = set_q & (~set_q + NUM_SECT'(1));
    assign last_o = (set_q != '0) && ((set_q & (set_q - NUM_SECT'(1))) == '0);
    assign set_o  = set_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)  set_q <= '0;
        else if (fill_i)     set_q <= '1;
        else if (retire_i)   set_q <= set_q & ~lowest;
        else if (add_i)      set_q <= set_q | (NUM_SECT'(1) << add_idx_i);
    end

    // R6: each completed sector removes exactly one bit
    p_retire_one_r6: assert property (@(posedge clk) disable iff (rst)
        (retire_i && !clear_i && !fill_i && set_q != '0)
        |=> ($countones(set_q) == $past($countones(set_q)) - 1));

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import fcd_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int SECT_W    = 3,
    parameter int ACC_CYC   = 5000,
    parameter int SUSP_CYC  = 3500,
    parameter int RST_CYC   = 3500,
    parameter int ERASE_CYC = 1000,
    parameter int PROG_CYC  = 100,
    localparam int CNT_W = $clog2(imax(imax(imax(ACC_CYC, SUSP_CYC), imax(RST_CYC, ERASE_CYC)), PROG_CYC) + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hwrst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              q_last_i,
    output fcd_state_e        state_o,
    output logic              clear_o,
    output logic              fill_o,
    output logic              retire_o,
    output logic              add_o,
    output logic [SECT_W-1:0] add_idx_o
);
    fcd_state_e        state;
    logic [CNT_W-1:0]  win;
    logic [CNT_W-1:0]  op;
    logic              at_a, at_b, d30, dsusp;

    assign at_a  = wr_addr_i[11:0] == ADR_A;
    assign at_b  = wr_addr_i[11:0] == ADR_B;
    assign d30   = wr_data_i == CMD_SECT;
    assign dsusp = wr_en_i && wr_data_i == CMD_SUSP;

    assign state_o   = state;
    assign add_idx_o = wr_addr_i[ADDR_W-1 -: SECT_W];
    assign add_o     = !hwrst_i && wr_en_i && d30 && (state == S_ERA_UNL2 || state == S_ACCUM);
    assign fill_o    = !hwrst_i && wr_en_i && state == S_ERA_UNL2 && at_a && wr_data_i == CMD_CHIP;
    assign clear_o   = hwrst_i || (wr_en_i && !d30 && state == S_ACCUM);
    assign retire_o  = !hwrst_i && state == S_ERASING && !dsusp && op == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_READ;
            win   <= '0;
            op    <= '0;
        end else if (hwrst_i && state != S_RESETTING) begin
            state <= S_RESETTING;
            win   <= CNT_W'(RST_CYC - 1);
        end else begin
            unique case (state)
                S_RESETTING: begin
                    if (win != '0)     win <= win - 1'b1;
                    else if (!hwrst_i) state <= S_READ;
                end
                S_READ: if (wr_en_i && at_a && wr_data_i == CMD_UNL_A) state <= S_UNL1;
                S_UNL1: if (wr_en_i)
                    state <= (at_b && wr_data_i == CMD_UNL_B) ? S_UNL2 : S_READ;
                S_UNL2: if (wr_en_i) begin
                    if (!at_a)                        state <= S_READ;
                    else if (wr_data_i == CMD_PROG)   state <= S_PGM_DATA;
                    else if (wr_data_i == CMD_ERASE)  state <= S_ERA_CMD;
                    else if (wr_data_i == CMD_IDENT)  state <= S_IDENT;
                    else                              state <= S_READ;
                end
                S_PGM_DATA: if (wr_en_i) begin
                    if (wr_data_i == CMD_EXIT) state <= S_READ;
                    else begin
                        state <= S_PROGRAMMING;
                        op    <= CNT_W'(PROG_CYC - 1);
                    end
                end
                S_ERA_CMD: if (wr_en_i)
                    state <= (at_a && wr_data_i == CMD_UNL_A) ? S_ERA_UNL1 : S_READ;
                S_ERA_UNL1: if (wr_en_i)
                    state <= (at_b && wr_data_i == CMD_UNL_B) ? S_ERA_UNL2 : S_READ;
                S_ERA_UNL2: if (wr_en_i) begin
                    if (d30) begin
                        state <= S_ACCUM;
                        win   <= CNT_W'(ACC_CYC - 1);
                    end else if (at_a && wr_data_i == CMD_CHIP) begin
                        state <= S_ERASING;
                        op    <= CNT_W'(ERASE_CYC - 1);
                    end else state <= S_READ;
                end
                S_ACCUM: begin
                    if (wr_en_i) begin
                        if (d30) win <= CNT_W'(ACC_CYC - 1);
                        else     state <= S_READ;
                    end else if (win == '0) begin
                        state <= S_ERASING;
                        op    <= CNT_W'(ERASE_CYC - 1);
                    end else win <= win - 1'b1;
                end
                S_ERASING: begin
                    if (dsusp) begin
                        state <= S_SUSP_LAT;
                        win   <= CNT_W'(SUSP_CYC - 1);
                    end else if (op == '0) begin
                        if (q_last_i) state <= S_READ;
                        else          op    <= CNT_W'(ERASE_CYC - 1);
                    end else op <= op - 1'b1;
                end
                S_PROGRAMMING: begin
                    if (op == '0) state <= S_READ;
                    else          op    <= op - 1'b1;
                end
                S_SUSP_LAT: begin
                    if (win == '0) state <= S_SUSPENDED;
                    else           win   <= win - 1'b1;
                end
                S_SUSPENDED: if (wr_en_i && d30) state <= S_ERASING;
                S_IDENT:     if (wr_en_i && wr_data_i == CMD_EXIT) state <= S_READ;
                default:     state <= S_READ;
            endcase
        end
    end

    // R4: an accepted sector re-arms the full window
    p_accum_rearm_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_ACCUM && wr_en_i && d30 && !hwrst_i)
        |=> (state == S_ACCUM && win == CNT_W'(ACC_CYC - 1)));

    // R7: during suspend latency nothing but the latency expiry changes state
    p_susp_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_SUSP_LAT && !hwrst_i)
        |=> (state == S_SUSP_LAT || state == S_SUSPENDED));

    // R11: a running program cannot be interrupted by writes
    p_prog_no_suspend_r11: assert property (@(posedge clk) disable iff (rst)
        (state == S_PROGRAMMING && !hwrst_i && op != '0) |=> (state == S_PROGRAMMING));

endmodule

// File: rtl/fcd_rdmux.sv
module fcd_rdmux
    import fcd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en_i,
    input  logic [7:0]  rd_addr_i,
    input  rd_mode_e    mode_i,
    input  logic [1:0]  lock_sel_i,
    output logic [15:0] rd_data_o,
    output logic        toggle_o
);
    logic tog;
    assign toggle_o = tog;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o <= '0;
            tog       <= 1'b0;
        end else if (rd_en_i) begin
            unique case (mode_i)
                RM_ARRAY:  rd_data_o <= 16'hFFFF;
                RM_IDENT:  rd_data_o <= (rd_addr_i == OFS_LOCK) ? lock_code(lock_sel_i) : 16'h0000;
                RM_STATUS: begin
                    tog       <= ~tog;
                    rd_data_o <= {9'b0, ~tog, 6'b0};
                end
                default:   rd_data_o <= rd_data_o;
            endcase
        end
    end

    // R9: every status read flips the toggle bit
    p_toggle_flip_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && mode_i == RM_STATUS) |=> (toggle_o != $past(toggle_o)));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_SECT  = 8,
    parameter int CLK_MHZ   = 100,
    parameter int ACCUM_US  = 50,
    parameter int SUSP_US   = 35,
    parameter int RST_US    = 35,
    parameter int ERASE_CYC = 1000,
    parameter int PROG_CYC  = 100
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hwrst_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [7:0]          wr_data_i,
    input  logic                rd_en_i,
    input  logic [7:0]          rd_addr_i,
    input  logic [1:0]          lock_sel_i,
    output logic [15:0]         rd_data_o,
    output logic                ready_o,
    output logic                toggle_o,
    output logic [NUM_SECT-1:0] erase_set_o
);
    localparam int SECT_W   = $clog2(NUM_SECT);
    localparam int ACC_CYC  = CLK_MHZ * ACCUM_US;
    localparam int SUSP_CYC = CLK_MHZ * SUSP_US;
    localparam int RST_CYC  = CLK_MHZ * RST_US;

    fcd_state_e        state;
    logic              clear, fill, retire, add, last;
    logic [SECT_W-1:0] add_idx;

    fcd_seq #(
        .ADDR_W(ADDR_W), .SECT_W(SECT_W), .ACC_CYC(ACC_CYC), .SUSP_CYC(SUSP_CYC),
        .RST_CYC(RST_CYC), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)
    ) seq_i (
        .clk(clk), .rst(rst), .hwrst_i(hwrst_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .q_last_i(last),
        .state_o(state), .clear_o(clear), .fill_o(fill), .retire_o(retire),
        .add_o(add), .add_idx_o(add_idx)
    );

    fcd_erase_q #(.NUM_SECT(NUM_SECT)) q_i (
        .clk(clk), .rst(rst), .clear_i(clear), .fill_i(fill), .retire_i(retire),
        .add_i(add), .add_idx_i(add_idx), .set_o(erase_set_o), .last_o(last)
    );

    fcd_rdmux rd_i (
        .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .mode_i(mode_of(state)), .lock_sel_i(lock_sel_i),
        .rd_data_o(rd_data_o), .toggle_o(toggle_o)
    );

    assign ready_o = !is_busy(state);

    // R10: hardware reset empties the erase set and forces busy
    p_reset_abort_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(hwrst_i) |=> (!ready_o && erase_set_o == '0));

    // R5: a non-sector write inside the window abandons the set
    p_accum_abort_r5: assert property (@(posedge clk) disable iff (rst)
        (state == S_ACCUM && wr_en_i && wr_data_i != CMD_SECT && !hwrst_i)
        |=> (ready_o && erase_set_o == '0));

endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
    localparam int ACC  = 50;
    localparam int SUSP = 35;
    localparam int RSTC = 35;
    localparam int ER   = 20;
    localparam int PG   = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hwrst_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [11:0] wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic        rd_en_i = 1'b0;
    logic [7:0]  rd_addr_i = '0;
    logic [1:0]  lock_sel_i = '0;
    logic [15:0] rd_data_o;
    logic        ready_o, toggle_o;
    logic [7:0]  erase_set_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    bit mon_due = 0;
    logic exp_tog = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    flash_cmd_decoder #(
        .ADDR_W(12), .NUM_SECT(8), .CLK_MHZ(1), .ACCUM_US(50), .SUSP_US(35),
        .RST_US(35), .ERASE_CYC(ER), .PROG_CYC(PG)
    ) dut_i (
        .clk(clk), .rst(rst), .hwrst_i(hwrst_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
        .rd_addr_i(rd_addr_i), .lock_sel_i(lock_sel_i), .rd_data_o(rd_data_o),
        .ready_o(ready_o), .toggle_o(toggle_o), .erase_set_o(erase_set_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: read data is due one edge after the strobe
    always @(posedge clk) if (rd_en_i) mon_due <= 1'b1;
    always @(negedge clk) begin
        if (mon_due) begin
            mon_due <= 1'b0;
            if (exp_q.size() == 0) chk("SB", 32'hDEAD, 32'h0);
            else chk(tag_q.pop_front(), {16'h0, rd_data_o}, {16'h0, exp_q.pop_front()});
        end
    end

    task automatic wr(logic [11:0] a, logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [15:0] exp, string req);
        exp_q.push_back(exp); tag_q.push_back(req);
        rd_en_i = 1'b1; rd_addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic rd_status(string req);
        exp_tog = ~exp_tog;
        rd(8'h00, {9'b0, exp_tog, 6'b0}, req);
    endtask

    task automatic unlock();
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
    endtask

    task automatic erase_pre();
        unlock(); wr(12'h555, 8'h80); unlock();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset ready", ready_o, 1);
        chk("reset set", erase_set_o, 0);
        chk("reset toggle", toggle_o, 0);

        // R1 program, R9 status toggle, R11 suspend ignored
        unlock(); wr(12'h555, 8'hA0); wr(12'h123, 8'h5A);
        chk("R1 busy", ready_o, 0);
        rd_status("R9 status1");
        chk("R9 toggle_o", toggle_o, exp_tog);
        rd_status("R9 status2");
        chk("R9 toggle_o back", toggle_o, exp_tog);
        wr(12'h000, 8'hB0);
        repeat (PG - 4) @(negedge clk);
        chk("R11 still busy", ready_o, 0);
        @(negedge clk);
        chk("R1 R11 done", ready_o, 1);

        // R2 broken unlock
        wr(12'h555, 8'hAA); wr(12'h2AB, 8'h55); wr(12'h555, 8'h90);
        rd(8'h06, 16'hFFFF, "R2 no ident");

        // R8 identification
        unlock(); wr(12'h555, 8'h90);
        lock_sel_i = 2'b00; rd(8'h06, 16'h0001, "R8 unlocked");
        lock_sel_i = 2'b01; rd(8'h06, 16'h0041, "R8 customer");
        lock_sel_i = 2'b10; rd(8'h06, 16'h0081, "R8 factory");
        rd(8'hA0, 16'h0000, "R8 no prog suspend");
        wr(12'h000, 8'hF0);
        rd(8'h06, 16'hFFFF, "R8 exit");

        // R12 F0 mid-sequence
        unlock(); wr(12'h555, 8'h80); wr(12'h555, 8'hAA); wr(12'h000, 8'hF0);
        wr(12'hA00, 8'h30);
        chk("R12 ready", ready_o, 1);
        chk("R12 set", erase_set_o, 0);
        rd(8'h00, 16'hFFFF, "R12 array");

        // R3 R4 R6 multi-sector with restarting window
        erase_pre(); wr(12'hA00, 8'h30);
        chk("R3 sector bit", erase_set_o, 8'h20);
        chk("R3 busy", ready_o, 0);
        repeat (39) @(negedge clk);
        wr(12'h400, 8'h30);
        repeat (39) @(negedge clk);
        wr(12'hC00, 8'h30);
        chk("R4 restart add", erase_set_o, 8'h64);
        repeat (ACC) @(negedge clk);
        chk("R6 start set", erase_set_o, 8'h64);
        repeat (ER) @(negedge clk);
        chk("R6 lowest first", erase_set_o, 8'h60);
        repeat (2 * ER - 1) @(negedge clk);
        chk("R6 still busy", ready_o, 0);
        chk("R6 last sector", erase_set_o, 8'h40);
        @(negedge clk);
        chk("R6 done", ready_o, 1);
        chk("R6 empty", erase_set_o, 0);

        // R4 late sector ignored
        erase_pre(); wr(12'h200, 8'h30);
        repeat (ACC) @(negedge clk);
        wr(12'hE00, 8'h30);
        chk("R4 late ignored", erase_set_o, 8'h02);
        repeat (ER - 2) @(negedge clk);
        chk("R4 busy", ready_o, 0);
        @(negedge clk);
        chk("R4 done", ready_o, 1);

        // R5 abort on unlock inside window
        erase_pre(); wr(12'h600, 8'h30);
        repeat (5) @(negedge clk);
        unlock();
        chk("R5 ready", ready_o, 1);
        chk("R5 set cleared", erase_set_o, 0);
        rd(8'h00, 16'hFFFF, "R5 array");

        // R7 suspend / resume
        erase_pre(); wr(12'h800, 8'h30);
        repeat (ACC) @(negedge clk);
        repeat (4) @(negedge clk);
        wr(12'h000, 8'hB0);
        chk("R7 busy", ready_o, 0);
        repeat (9) @(negedge clk);
        wr(12'h800, 8'h30);
        repeat (SUSP - 11) @(negedge clk);
        chk("R7 latency busy", ready_o, 0);
        @(negedge clk);
        chk("R7 suspended ready", ready_o, 1);
        chk("R7 set kept", erase_set_o, 8'h10);
        rd(8'h00, 16'hFFFF, "R7 array while suspended");
        wr(12'h000, 8'h30);
        chk("R7 resumed", ready_o, 0);
        repeat (ER - 5) @(negedge clk);
        chk("R7 progress kept busy", ready_o, 0);
        @(negedge clk);
        chk("R7 done", ready_o, 1);
        chk("R7 empty", erase_set_o, 0);

        // R3 chip erase, R10 hardware reset
        erase_pre(); wr(12'h555, 8'h10);
        chk("R3 chip set", erase_set_o, 8'hFF);
        repeat (3) @(negedge clk);
        hwrst_i = 1'b1;
        @(negedge clk);
        chk("R10 busy", ready_o, 0);
        chk("R10 cleared", erase_set_o, 0);
        repeat (2) @(negedge clk);
        hwrst_i = 1'b0;
        unlock();
        repeat (RSTC - 5) @(negedge clk);
        chk("R10 recovery busy", ready_o, 0);
        @(negedge clk);
        chk("R10 recovered", ready_o, 1);
        wr(12'h555, 8'h90);
        rd(8'h06, 16'hFFFF, "R10 writes ignored");

        @(negedge clk);
        chk("SB drained", exp_q.size(), 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule